// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low external interrupt pin into a latched interrupt request for a CPU. The pin is brought into the clock domain through a synchronizer, and a falling edge sets a pending latch. A mode bit adds level sensitivity. In level mode a low pin keeps the request pending, and clearing the latch needs both an acknowledge and the pin back at logic 1, in either order. In edge mode an acknowledge clears the latch at once.

An acknowledge comes either from the CPU fetching the interrupt vector (address 0xFFFA or 0xFFFB with the fetch strobe high) or from software writing 1 to the acknowledge bit of the status/control register. A mask bit gates the request to the CPU. The pending flag is always readable, so software can poll the pin while the request is masked.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is asserted and after reset, mode, mask and the pending flag read 0 and irq_req_o is 0.
- R2: In edge mode a falling pin edge sets the pending flag (register bit 3) three clock edges after the pin changes. With mask clear, irq_req_o rises at the same time.
- R3: In edge mode, writing 1 to bit 2 (acknowledge) clears the pending flag on that clock edge. A pin that stays low does not set the flag again.
- R4: A vector fetch strobe with address 0xFFFA or 0xFFFB acknowledges like R3. A fetch at any other address has no effect.
- R5: In level mode (bit 0 = 1) the pending flag clears only after both an acknowledge and a synchronized high pin level have been seen, in either order.
- R6: The mask (bit 1 = 1) forces irq_req_o low but leaves the pending flag readable. Clearing the mask while a request is pending raises irq_req_o.
- R7: In level mode a low synchronized pin sets the pending flag without any edge, for example when level mode is enabled while the pin is held low.
- R8: When a falling edge and an acknowledge arrive in the same cycle, the edge wins and the flag stays set.
- R9: An acknowledge does not block later pin activity: a falling edge after an acknowledge sets the flag again.
- R10: Reset clears the pending flag and the mode bit even if the pin stays low. A pin held low through reset does not count as an edge after reset.
- R11: Bit 2 always reads 0. Writes to bits 3 and 4 are ignored.
- R12: Bit 4 and pin_level_o show the synchronized pin level. This level is 0 during reset and for two cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_ni | input | 1 | Asynchronous active-low interrupt pin |
| reg_we_i | input | 1 | Status/control register write strobe |
| reg_wdata_i | input | DATA_W | Write data: bit 0 mode, bit 1 mask, bit 2 acknowledge |
| reg_rdata_o | output | DATA_W | Read data: bit 0 mode, bit 1 mask, bit 2 zero, bit 3 pending, bit 4 pin level |
| vec_fetch_i | input | 1 | CPU vector fetch strobe |
| vec_addr_i | input | ADDR_W | CPU vector fetch address |
| irq_req_o | output | 1 | Masked interrupt request to the CPU |
| pin_level_o | output | 1 | Synchronized pin level |

## Verification
A wrong pending or acknowledge-seen state becomes visible at the ports within one clock. irq_req_o and register bit 3 diverge from the reference on the next edge after an acknowledge, a pin return or a new edge. A fault in the synchronizer shifts every set and clear by whole cycles, so the per-cycle comparison catches it at the first pin transition. Each order of the level-mode clear and each same-cycle collision is driven on purpose, so a swapped priority shows as a single-cycle miscompare.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned MODE_BIT = 0;
  localparam int unsigned MASK_BIT = 1;
  localparam int unsigned ACK_BIT  = 2;
  localparam int unsigned FLAG_BIT = 3;
  localparam int unsigned PIN_BIT  = 4;
  localparam int unsigned CSR_USED = 5;

  typedef struct packed {
    logic lvl_mode;
    logic masked;
  } irq_ctrl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  // reset low: a pin held low through reset is not seen as an edge
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= pin_ni;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], pin_ni};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[LAST];
  end

  assign level_o = chain_q[LAST];
  assign fall_o  = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import ext_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pend_i,
  input  logic              pin_lvl_i,
  output irq_ctrl_t         ctrl_o,
  output logic              ack_sw_o,
  output logic [DATA_W-1:0] rdata_o
);
  irq_ctrl_t ctrl_q;
  logic      wdata_unused;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.lvl_mode <= wdata_i[MODE_BIT];
      ctrl_q.masked   <= wdata_i[MASK_BIT];
    end
  end

  assign ack_sw_o     = we_i & wdata_i[ACK_BIT];
  assign ctrl_o       = ctrl_q;
  assign wdata_unused = ^wdata_i[DATA_W-1:FLAG_BIT];

  always_comb begin
    rdata_o           = '0;
    rdata_o[MODE_BIT] = ctrl_q.lvl_mode;
    rdata_o[MASK_BIT] = ctrl_q.masked;
    rdata_o[FLAG_BIT] = pend_i;
    rdata_o[PIN_BIT]  = pin_lvl_i;
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_mode_i,
  input  logic fall_i,
  input  logic pin_hi_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q, pend_d;
  logic seen_q, seen_d;

  always_comb begin
    pend_d = pend_q;
    seen_d = seen_q;
    if (fall_i) begin
      pend_d = 1'b1;            // edge beats a same-cycle ack
      seen_d = 1'b0;
    end else if (lvl_mode_i) begin
      if (pend_q) begin
        if ((ack_i || seen_q) && pin_hi_i) begin
          pend_d = 1'b0;
          seen_d = 1'b0;
        end else if (ack_i) begin
          seen_d = 1'b1;
        end
      end else if (!pin_hi_i) begin
        pend_d = 1'b1;
      end
    end else begin
      seen_d = 1'b0;
      if (ack_i) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      seen_q <= seen_d;
    end
  end

  assign pend_o = pend_q;

  // R8
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> pend_q);
  // R3
  ack_edge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode_i && ack_i && !fall_i) |=> !pend_q);
  // R7
  low_level_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_mode_i && !pin_hi_i) |=> pend_q);
  // R5
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_mode_i && pend_q && !ack_i && !seen_q) |=> pend_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 'hFFFA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_pin_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              vec_fetch_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  output logic              irq_req_o,
  output logic              pin_level_o
);
  localparam logic [ADDR_W-1:0] VEC_NEXT = VEC_BASE + ADDR_W'(1);

  logic      pin_lvl, pin_fall, pend, ack_sw, ack_hw;
  irq_ctrl_t ctrl;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_ni  (irq_pin_ni),
    .level_o (pin_lvl),
    .fall_o  (pin_fall)
  );

  irq_csr #(.DATA_W(DATA_W)) u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .pend_i    (pend),
    .pin_lvl_i (pin_lvl),
    .ctrl_o    (ctrl),
    .ack_sw_o  (ack_sw),
    .rdata_o   (reg_rdata_o)
  );

  assign ack_hw = vec_fetch_i & ((vec_addr_i == VEC_BASE) | (vec_addr_i == VEC_NEXT));

  irq_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_mode_i (ctrl.lvl_mode),
    .fall_i     (pin_fall),
    .pin_hi_i   (pin_lvl),
    .ack_i      (ack_sw | ack_hw),
    .pend_o     (pend)
  );

  assign irq_req_o   = pend & ~ctrl.masked;
  assign pin_level_o = pin_lvl;

  // R6
  req_implies_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> reg_rdata_o[FLAG_BIT]);
  // R4
  vec_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_i && vec_addr_i == VEC_BASE && !reg_rdata_o[MODE_BIT] && !pin_fall) |=> !reg_rdata_o[FLAG_BIT]);
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        vf = 1'b0;
  logic [15:0] va = '0;
  logic        req, lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_ni(pin), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .vec_fetch_i(vf),
    .vec_addr_i(va), .irq_req_o(req), .pin_level_o(lvl)
  );

  // behavioural reference
  bit m_hist[$] = '{0, 0, 0};
  bit m_pend, m_seen, m_mode, m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '{0, 0, 0};
      m_pend = 0; m_seen = 0; m_mode = 0; m_mask = 0;
    end else begin
      bit fall, hi, ack;
      fall = m_hist[2] && !m_hist[1];
      hi   = m_hist[1];
      ack  = (we && wdata[2]) || (vf && (va == 16'hFFFA || va == 16'hFFFB));
      if (fall) begin
        m_pend = 1; m_seen = 0;
      end else if (m_mode) begin
        if (m_pend && (ack || m_seen) && hi) begin m_pend = 0; m_seen = 0; end
        else if (m_pend && ack) m_seen = 1;
        else if (!m_pend && !hi) m_pend = 1;
      end else begin
        m_seen = 0;
        if (ack) m_pend = 0;
      end
      if (we) begin m_mode = wdata[0]; m_mask = wdata[1]; end
      m_hist.push_front(pin);
      void'(m_hist.pop_back());
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      exp_rd = {3'b000, m_hist[1], m_pend, 1'b0, m_mask, m_mode};
      check("R2 R5 R6 R12 per-cycle model", {6'd0, req, lvl, rdata},
            {6'd0, m_pend && !m_mask, m_hist[1], exp_rd});
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [7:0] d);
    we = 1'b1; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic vfetch(logic [15:0] a);
    vf = 1'b1; va = a;
    step(1);
    vf = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2);
    check("R1 reset req", {15'd0, req}, 16'd0);
    check("R1 reset regs", {8'd0, rdata}, 16'h0000);
    rst_n = 1'b1;
    step(3);
    check("R12 pin high visible", {7'd0, lvl, rdata}, {7'd0, 1'b1, 8'h10});

    // edge mode
    pin = 1'b0; step(3);
    check("R2 edge sets", {7'd0, req, rdata}, {7'd0, 1'b1, 8'h08});
    wr(8'h04);
    check("R3 ack clears", {15'd0, req}, 16'd0);
    step(3);
    check("R3 low pin no reset", {15'd0, req}, 16'd0);
    check("R12 pin low visible", {15'd0, lvl}, 16'd0);

    pin = 1'b1; step(3);
    wr(8'h04);
    pin = 1'b0; step(3);
    check("R9 edge after ack", {15'd0, req}, 16'd1);
    vfetch(16'hFFF0);
    check("R4 other addr ignored", {15'd0, req}, 16'd1);
    vfetch(16'hFFFB);
    check("R4 vector ack", {15'd0, req}, 16'd0);

    // mask
    pin = 1'b1; step(3);
    wr(8'h02);
    pin = 1'b0; step(3);
    check("R6 masked", {7'd0, req, rdata[3:0]}, {7'd0, 1'b0, 8'h0A});
    wr(8'h00);
    check("R6 unmask", {15'd0, req}, 16'd1);
    wr(8'h04);

    // level mode: ack first
    pin = 1'b1; step(3);
    wr(8'h01);
    pin = 1'b0; step(3);
    check("R5 level set", {15'd0, req}, 16'd1);
    wr(8'h05); step(4);
    check("R5 ack while low", {15'd0, req}, 16'd1);
    pin = 1'b1; step(3);
    check("R5 clear after return", {15'd0, req}, 16'd0);
    // level mode: return first
    pin = 1'b0; step(3);
    pin = 1'b1; step(4);
    check("R5 return alone", {15'd0, req}, 16'd1);
    wr(8'h05);
    check("R5 clear after ack", {15'd0, req}, 16'd0);

    // level enable while low
    wr(8'h00);
    pin = 1'b0; step(3);
    wr(8'h04);
    check("R3 cleared before mode", {15'd0, req}, 16'd0);
    wr(8'h01); step(1);
    check("R7 low level sets", {15'd0, req}, 16'd1);
    pin = 1'b1; step(3);
    wr(8'h05);
    check("R7 clear", {15'd0, req}, 16'd0);

    // edge vs ack same cycle
    wr(8'h00);
    pin = 1'b0; step(2);
    we = 1'b1; wdata = 8'h04; step(1); we = 1'b0;
    check("R8 edge wins", {15'd0, req}, 16'd1);

    // reset with pin low and level mode
    wr(8'h04);
    wr(8'h01); step(1);
    check("R10 pending before reset", {15'd0, req}, 16'd1);
    rst_n = 1'b0; step(1);
    check("R10 reset clears", {7'd0, req, rdata}, 16'd0);
    rst_n = 1'b1; step(4);
    check("R10 no edge after reset", {7'd0, req, rdata[3:0]}, 16'd0);

    // write-only / read-only bits
    wr(8'h1F);
    check("R11 ack reads 0 flag ignored", {12'd0, rdata[3:0]}, 16'h0003);
    step(2);
    wr(8'h04);
    pin = 1'b1; step(3);
    wr(8'h04); step(2);
    check("R11 final idle", {7'd0, req, rdata}, {7'd0, 1'b0, 8'h10});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule